// File: doc/BRIEF.md
# Reference-Tick Synchronized Start Controller

This block derives a symmetric reference square wave from the system clock and marks one fixed cycle of every reference period as the decision tick. Several copies of the block, each driven by the same clock, can be brought into phase with each other. Each copy shifts its own wave by a programmable cycle offset, so all of them end up raising their reference edge in the same cycle.

The external enable is not acted on when it changes. It is latched once per period, in the first high cycle of the reference wave. That latched copy stays stable until the tick, which lies a fixed number of cycles later. At the tick a control state machine either launches the PWM bank with a one-cycle start strobe or halts it with a one-cycle stop strobe. Every copy that shares the clock and the aligned reference therefore starts and stops its outputs in the same cycle. An enable that arrives too late for one capture is acted on exactly one reference period later.

The wave generator has two states. COUNT steps a position counter through one period. HOLD keeps the wave low for extra cycles to absorb a phase change. Its transitions are WRAP (COUNT to COUNT at the end of a period with no phase change), DEFER (COUNT to HOLD when the offset changed) and RESUME (HOLD to COUNT when the extra cycles are used up). The control machine has the states IDLE and RUN, with the transitions GO (IDLE to RUN at a tick with the latched enable high) and HALT (RUN to IDLE at a tick with the latched enable low).

Top module: `ref_sync_start`

## Requirements
- R1: With the offset input unchanged, ref_o is high for HALF_CYCLES cycles and then low for HALF_CYCLES cycles, so one period is 2*HALF_CYCLES cycles.
- R2: While rst_ni is low, ref_o is 1 (position 0 of a period) and start_o, stop_o and run_o are 0. The first cycle after reset is the first high cycle of a period.
- R3: en_i is sampled only in the first high cycle of ref_o. A change of en_i in any other cycle has no effect on start_o, stop_o or run_o, as long as it is undone before the next sampling cycle.
- R4: When the sampled enable is 1 and the block is in IDLE, start_o is high for exactly one cycle, TICK_POS+1 cycles after the first high cycle of that period (TICK_POS counted from position 0).
- R5: When the sampled enable is 0 and the block is in RUN, stop_o is high for exactly one cycle, TICK_POS+1 cycles after the first high cycle of that period.
- R6: An enable change made just after its sampling cycle produces its strobe exactly one period later, 2*HALF_CYCLES+TICK_POS+1 cycles after that period's first high cycle.
- R7: phase_i (unsigned, a value below 2*HALF_CYCLES) is applied only at the end of a period. The next low phase is lengthened by (new - old) mod 2*HALF_CYCLES cycles. The high phase is never shortened, and strobe timing relative to the next rising edge is unchanged.
- R8: run_o is 1 from the cycle start_o is high up to the cycle before stop_o is high, and 0 otherwise.
- R9: start_o and stop_o are never high together. An enable held at one level for many periods produces no further strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Requested run state, sampled once per period |
| phase_i | input | $clog2(2*HALF_CYCLES) | Wave offset in clock cycles, applied at a period end |
| ref_o | output | 1 | Symmetric reference square wave |
| start_o | output | 1 | One-cycle strobe launching the PWM bank |
| stop_o | output | 1 | One-cycle strobe halting the PWM bank |
| run_o | output | 1 | High while the control machine is in RUN |

## Verification
If the position counter or the HOLD bookkeeping is wrong, the first affected period has a wrong length, seen on ref_o within one or two periods as a high or low run of the wrong size. This is why every offset step is measured on the edge after it is applied. If the latched enable or the control state is wrong, a strobe appears at the wrong distance from the rising edge, appears one period early or late, or repeats while the enable is held. Each of these can be seen within one period of the stimulus. The enable is therefore moved on both sides of its sampling cycle, and strobe latencies are counted from the observed rising edge.

// File: rtl/ref_sync_start_pkg.sv
package ref_sync_start_pkg;

    typedef enum logic {
        WV_COUNT,
        WV_HOLD
    } wave_state_t;

    typedef enum logic {
        SS_IDLE,
        SS_RUN
    } ctrl_state_t;

endpackage

// File: rtl/ref_wave_gen.sv
module ref_wave_gen
    import ref_sync_start_pkg::*;
#(
    parameter int HALF_CYCLES = 124,
    parameter int TICK_POS    = 8,
    localparam int PERIOD     = 2 * HALF_CYCLES,
    localparam int CW         = $clog2(PERIOD)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [CW-1:0] phase_i,
    output logic          ref_o,
    output logic          rise_o,
    output logic          tick_o
);

    localparam logic [CW-1:0] LAST_POS = CW'(PERIOD - 1);
    localparam logic [CW-1:0] HALF_POS = CW'(HALF_CYCLES);
    localparam logic [CW-1:0] TICK_AT  = CW'(TICK_POS);

    wave_state_t   state_q;
    logic [CW-1:0] pos_q;
    logic [CW-1:0] hold_left_q;
    logic [CW-1:0] applied_off_q;
    logic [CW-1:0] req_off;
    logic [CW:0]   diff_wide;
    logic [CW-1:0] shift_amt;

    // Offsets beyond one period are clamped to the last position.
    always_comb begin
        if ({1'b0, phase_i} >= (CW+1)'(PERIOD)) begin
            req_off = LAST_POS;
        end else begin
            req_off = phase_i;
        end
        diff_wide = {1'b0, req_off} + (CW+1)'(PERIOD) - {1'b0, applied_off_q};
        if (diff_wide >= (CW+1)'(PERIOD)) begin
            diff_wide = diff_wide - (CW+1)'(PERIOD);
        end
        shift_amt = diff_wide[CW-1:0];
    end

    // State register: position counter and hold window.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q       <= WV_COUNT;
            pos_q         <= '0;
            hold_left_q   <= '0;
            applied_off_q <= '0;
        end else begin
            unique case (state_q)
                WV_COUNT: begin
                    if (pos_q == LAST_POS) begin
                        applied_off_q <= req_off;
                        pos_q         <= '0;
                        if (shift_amt != '0) begin
                            state_q     <= WV_HOLD;   // DEFER
                            hold_left_q <= shift_amt;
                        end                           // else WRAP
                    end else begin
                        pos_q <= pos_q + 1'b1;
                    end
                end
                WV_HOLD: begin
                    if (hold_left_q == CW'(1)) begin
                        state_q <= WV_COUNT;          // RESUME
                    end
                    hold_left_q <= hold_left_q - 1'b1;
                end
                default: state_q <= WV_COUNT;
            endcase
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        ref_o  = 1'b0;
        rise_o = 1'b0;
        tick_o = 1'b0;
        unique case (state_q)
            WV_COUNT: begin
                ref_o  = (pos_q < HALF_POS);
                rise_o = (pos_q == '0);
                tick_o = (pos_q == TICK_AT);
            end
            WV_HOLD: begin
                ref_o = 1'b0;
            end
            default: ref_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/en_edge_latch.sv
module en_edge_latch (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic rise_i,
    input  logic en_i,
    output logic en_cap_o
);

    // Loaded only in the first high cycle of the reference wave.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            en_cap_o <= 1'b0;
        end else if (rise_i) begin
            en_cap_o <= en_i;
        end
    end

endmodule

// File: rtl/sync_ctrl_fsm.sv
module sync_ctrl_fsm
    import ref_sync_start_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic en_cap_i,
    output logic start_o,
    output logic stop_o,
    output logic run_o
);

    ctrl_state_t state_q;
    ctrl_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SS_IDLE: if (tick_i && en_cap_i)  state_d = SS_RUN;   // GO
            SS_RUN:  if (tick_i && !en_cap_i) state_d = SS_IDLE;  // HALT
            default: state_d = SS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= SS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: strobes mark the transition edge.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            start_o <= 1'b0;
            stop_o  <= 1'b0;
        end else begin
            start_o <= (state_q == SS_IDLE) && (state_d == SS_RUN);
            stop_o  <= (state_q == SS_RUN)  && (state_d == SS_IDLE);
        end
    end

    assign run_o = (state_q == SS_RUN);

endmodule

// File: rtl/ref_sync_start.sv
module ref_sync_start #(
    parameter int HALF_CYCLES = 124,
    parameter int TICK_POS    = 8,
    localparam int PERIOD     = 2 * HALF_CYCLES,
    localparam int PW         = $clog2(PERIOD)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          en_i,
    input  logic [PW-1:0] phase_i,
    output logic          ref_o,
    output logic          start_o,
    output logic          stop_o,
    output logic          run_o
);

    logic rise;
    logic tick;
    logic en_cap;

    ref_wave_gen #(
        .HALF_CYCLES (HALF_CYCLES),
        .TICK_POS    (TICK_POS)
    ) u_wave (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .phase_i (phase_i),
        .ref_o   (ref_o),
        .rise_o  (rise),
        .tick_o  (tick)
    );

    en_edge_latch u_latch (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .rise_i   (rise),
        .en_i     (en_i),
        .en_cap_o (en_cap)
    );

    sync_ctrl_fsm u_ctrl (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick),
        .en_cap_i (en_cap),
        .start_o  (start_o),
        .stop_o   (stop_o),
        .run_o    (run_o)
    );

endmodule

// File: rtl/ref_sync_start_chk.sv
module ref_sync_start_chk #(
    parameter int HALF_CYCLES = 124,
    parameter int TICK_POS    = 8
) (
    input logic clk_i,
    input logic rst_ni,
    input logic ref_o,
    input logic start_o,
    input logic stop_o,
    input logic run_o
);

    logic        ref_q;
    logic        seen_fall;
    logic [15:0] hi_run;
    logic [15:0] lo_run;
    logic [15:0] since_rise;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ref_q      <= 1'b0;
            seen_fall  <= 1'b0;
            hi_run     <= '0;
            lo_run     <= '0;
            since_rise <= '0;
        end else begin
            ref_q  <= ref_o;
            hi_run <= ref_o ? ((hi_run != 16'hFFFF) ? hi_run + 16'd1 : hi_run) : '0;
            lo_run <= !ref_o ? ((lo_run != 16'hFFFF) ? lo_run + 16'd1 : lo_run) : '0;
            if (!ref_o && ref_q) seen_fall <= 1'b1;
            if (ref_o && !ref_q) begin
                since_rise <= 16'd1;
            end else if (since_rise != 16'hFFFF) begin
                since_rise <= since_rise + 16'd1;
            end
        end
    end

    p_high_limit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ref_o |-> (hi_run < 16'(HALF_CYCLES)));

    p_low_floor_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ref_o && !ref_q && seen_fall) |-> (lo_run >= 16'(HALF_CYCLES)));

    p_no_runt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ref_o && ref_q) |-> (hi_run == 16'(HALF_CYCLES)));

    p_start_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |=> !start_o);

    p_stop_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_o |=> !stop_o);

    p_strobe_at_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_o || stop_o) |-> (since_rise == 16'(TICK_POS + 1)));

    p_start_runs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |-> run_o);

    p_stop_idles_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_o |-> !run_o);

    p_run_changes_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_o != $past(run_o)) |-> (start_o || stop_o));

    p_no_overlap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(start_o && stop_o));

endmodule

bind ref_sync_start ref_sync_start_chk #(
    .HALF_CYCLES (HALF_CYCLES),
    .TICK_POS    (TICK_POS)
) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ref_o   (ref_o),
    .start_o (start_o),
    .stop_o  (stop_o),
    .run_o   (run_o)
);

// File: tb/ref_sync_start_bench.sv
`timescale 1ns/1ps
module ref_sync_start_bench;

    localparam int H  = 4;
    localparam int T  = 3;
    localparam int P  = 2 * H;
    localparam int PW = $clog2(P);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic [PW-1:0] phase = '0;
    logic          ref_w;
    logic          start_w;
    logic          stop_w;
    logic          run_w;

    always #5 clk = ~clk;

    ref_sync_start #(
        .HALF_CYCLES (H),
        .TICK_POS    (T)
    ) u_ref_sync_start (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .en_i    (en),
        .phase_i (phase),
        .ref_o   (ref_w),
        .start_o (start_w),
        .stop_o  (stop_w),
        .run_o   (run_w)
    );

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    // Monitor state, updated shortly after each rising clock edge.
    int  smp = 0;
    int  last_rise = 0;
    int  last_fall = 0;
    int  period_len = 0;
    int  hi_len = 0;
    int  lo_len = 0;
    int  n_start = 0;
    int  n_stop = 0;
    int  last_start = 0;
    int  last_stop = 0;
    int  wide = 0;
    int  overlap = 0;
    logic ref_q = 1'b0;
    logic start_q = 1'b0;
    logic stop_q = 1'b0;
    event ev_rise;
    event ev_start;
    event ev_stop;

    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            ref_q   = ref_w;
            start_q = 1'b0;
            stop_q  = 1'b0;
            smp     = 0;
        end else begin
            smp++;
            if (!ref_w && ref_q) begin
                hi_len    = smp - last_rise;
                last_fall = smp;
            end
            if (ref_w && !ref_q) begin
                period_len = smp - last_rise;
                lo_len     = smp - last_fall;
                last_rise  = smp;
                ->ev_rise;
            end
            if (start_w && start_q) wide++;
            if (stop_w && stop_q) wide++;
            if (start_w && stop_w) overlap++;
            if (start_w) begin
                n_start++;
                last_start = smp;
                ->ev_start;
            end
            if (stop_w) begin
                n_stop++;
                last_stop = smp;
                ->ev_stop;
            end
            ref_q   = ref_w;
            start_q = start_w;
            stop_q  = stop_w;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int r;
        int s0;
        int old_off;
        int new_off;

        // R2: values held during reset
        repeat (3) @(negedge clk);
        chk("R2 ref_o in reset", int'(ref_w), 1);
        chk("R2 start_o in reset", int'(start_w), 0);
        chk("R2 stop_o in reset", int'(stop_w), 0);
        chk("R2 run_o in reset", int'(run_w), 0);
        rst_n = 1'b1;

        // R1: symmetric wave with a fixed offset
        @(ev_rise);
        for (int k = 0; k < 3; k++) begin
            @(ev_rise);
            chk("R1 period", period_len, P);
            chk("R1 high run", hi_len, H);
            chk("R1 low run", lo_len, H);
        end

        // R4 / R3: enable set before its sampling cycle
        @(ev_rise);
        r = last_rise;
        @(negedge clk);
        en = 1'b1;
        @(ev_start);
        chk("R4 start latency", last_start - r, T + 1);
        repeat (2) @(negedge clk);
        chk("R4 start one cycle", int'(start_w), 0);
        chk("R8 run after start", int'(run_w), 1);

        // R9: held enable gives no further strobes
        s0 = n_start;
        repeat (4) @(ev_rise);
        repeat (T + 3) @(negedge clk);
        chk("R9 no repeat start", n_start, s0);
        chk("R9 no stop while held", n_stop, 0);

        // R5: enable cleared before sampling
        @(ev_rise);
        r = last_rise;
        @(negedge clk);
        en = 1'b0;
        @(ev_stop);
        chk("R5 stop latency", last_stop - r, T + 1);
        repeat (2) @(negedge clk);
        chk("R5 stop one cycle", int'(stop_w), 0);
        chk("R8 idle after stop", int'(run_w), 0);

        // R3: pulse between sampling cycles is ignored
        s0 = n_start;
        @(ev_rise);
        @(negedge clk);
        @(negedge clk);
        en = 1'b1;
        repeat (3) @(negedge clk);
        en = 1'b0;
        repeat (2) @(ev_rise);
        repeat (T + 3) @(negedge clk);
        chk("R3 ignored pulse start count", n_start, s0);
        chk("R3 ignored pulse run_o", int'(run_w), 0);

        // R6: enable just after sampling slips one period
        @(ev_rise);
        r = last_rise;
        @(negedge clk);
        @(negedge clk);
        en = 1'b1;
        @(ev_start);
        chk("R6 late start latency", last_start - r, P + T + 1);
        @(ev_rise);
        r = last_rise;
        @(negedge clk);
        @(negedge clk);
        en = 1'b0;
        @(ev_stop);
        chk("R6 late stop latency", last_stop - r, P + T + 1);

        chk("R4 R5 strobe width", wide, 0);
        chk("R9 strobe overlap", overlap, 0);

        // R7: sweep every shift size
        old_off = 0;
        @(ev_rise);
        for (int d = 0; d < P; d++) begin
            new_off = (old_off + d) % P;
            @(negedge clk);
            phase = PW'(new_off);
            @(ev_rise);
            chk("R7 shifted period", period_len, P + d);
            chk("R7 shifted low run", lo_len, H + d);
            chk("R7 high kept", hi_len, H);
            old_off = new_off;
        end

        // R7 / R4: strobe timing after a shift
        @(ev_rise);
        r = last_rise;
        @(negedge clk);
        en = 1'b1;
        @(ev_start);
        chk("R7 start latency after shift", last_start - r, T + 1);
        repeat (2) @(negedge clk);
        chk("R4 R5 strobe width final", wide, 0);

        finish_run();
    end

endmodule